// File: doc/BRIEF.md
# Remapped Vector Loop Sequencer

This block walks one vector operation across its elements, one element per clock, and for each element produces the register numbers of a destination and two sources. Each operand's register number is its base register plus an element offset. A vector operand's offset is the element number; a scalar operand's offset is zero. Each operand may pass that offset through one of four shared shape configurations, which reorder it as a 1D, 2D or 3D index in any axis order, with an optional starting shift. This supports transposed matrix walks, element cycling and mid-register access without moving any data.

A per-element predicate decides which elements are issued. Elements that are switched off still take their cycle. A scalar destination ends the loop after its first issued element. A state register always holds the element in progress. When an issued element would reach a register number at or beyond the register-file size, the block stops with an error and keeps that element number, so that a later start with the resume flag continues from it. The register file and the arithmetic unit sit outside. The block only emits the issue strobe, the indices, and done/error pulses. Configuration inputs are expected to stay stable while the block is busy.

Top module: `vloop_seq`

## Requirements
- R1: After reset `busy`, `issue`, `done` and `err` are low and `elem_state` is 0.
- R2: A `start` seen while idle loads `elem_state` with the first element on the next cycle. Each following clock processes one element in increasing order up to `vl`-1, and `elem_state` equals the element whose result appears in that same cycle.
- R3: Element i raises `issue` only when `pred[i]` is 1. An element whose predicate bit is 0 still uses one cycle and advances the element number, but it raises no strobe.
- R4: An operand's offset is the element number when its vector flag is 1, and 0 when the flag is 0. Its register number is its base plus its offset, or plus the remapped offset when a map is selected.
- R5: A shape is 13 bits at `shape_cfg[13*k +: 13]`, laid out as follows:
  - bits 3:0 are the shift s.
  - bits 6:4 are the axis order code. 0 selects xyz, 1 xzy, 2 yxz, 3 yzx, 4 zxy and 5 zyx, with the first-named axis varying fastest. Codes 6 and 7 act as 0.
  - bits 8:7, 10:9 and 12:11 hold the x, y and z sizes minus one.

  The remapped offset of offset e is found by stepping an (x,y,z) counter e+s times from (0,0,0) in the chosen order, wrapping each axis at its size. The result is x + y*X + z*X*Y.
- R6: A 3-bit map select uses bit 2 to enable remapping and bits 1:0 to pick the shape.
- R7: When the destination is scalar (`rd_vec`=0), the loop finishes in the cycle of its first issued element.
- R8: `done` pulses for one cycle together with the last element (`vl`-1, or the early stop of R7), and `busy` is low afterwards. When `vl` is 0, or the resume point is not below `vl`, `done` pulses one cycle after `start` and nothing is issued.
- R9: If an element whose predicate bit is 1 has any operand register number of `NREG` or more, `err` pulses instead of `issue`. The loop then stops, and `elem_state` keeps that element. Elements whose predicate bit is 0 are never checked.
- R10: `start` with `resume`=1 begins at the element held in `elem_state`, and `start` with `resume`=0 begins at element 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (taken while idle) |
| resume | input | 1 | Begin at the saved element rather than 0 |
| vl | input | 7 | Vector length |
| pred | input | 64 | Per-element predicate bits |
| rd_base | input | REGW (5) | Destination base register |
| rs1_base | input | REGW (5) | Source 1 base register |
| rs2_base | input | REGW (5) | Source 2 base register |
| rd_vec | input | 1 | Destination is a vector |
| rs1_vec | input | 1 | Source 1 is a vector |
| rs2_vec | input | 1 | Source 2 is a vector |
| rd_map | input | 3 | Destination map select |
| rs1_map | input | 3 | Source 1 map select |
| rs2_map | input | 3 | Source 2 map select |
| shape_cfg | input | 52 | Four packed shape configurations |
| busy | output | 1 | Loop in progress |
| issue | output | 1 | Element issued this cycle |
| rd_idx | output | REGW (5) | Destination register number |
| rs1_idx | output | REGW (5) | Source 1 register number |
| rs2_idx | output | REGW (5) | Source 2 register number |
| done | output | 1 | Operation finished |
| err | output | 1 | Register-file over-run, loop halted |
| elem_state | output | 6 | Saved element number |

## Verification
Every shape size from 1x1x1 to 4x4x4 is swept with all six axis orders and a shift that changes from case to case, and the vector length is stretched past the shape's element count. This separates wrong axis order, wrong stride and missing wrap-around. Alternating, random and all-zero predicates show whether skipped elements still advance the counter. Scalar sources and destinations, a zero length, an over-run on an issued element against one on a skipped element, and a chain of resumes after an error cover the early-stop and re-entry paths.

// File: rtl/vls_pkg.sv
`timescale 1ns/1ps
package vls_pkg;

  typedef enum logic {SEQ_IDLE, SEQ_RUN} seq_st_t;

  // Axis order code -> {third, second, first} axis, 2 bits each (0=x,1=y,2=z)
  function automatic logic [5:0] perm_order(input logic [2:0] code);
    case (code)
      3'd1:    return {2'd1, 2'd2, 2'd0};
      3'd2:    return {2'd2, 2'd0, 2'd1};
      3'd3:    return {2'd0, 2'd2, 2'd1};
      3'd4:    return {2'd1, 2'd0, 2'd2};
      3'd5:    return {2'd0, 2'd1, 2'd2};
      default: return {2'd2, 2'd1, 2'd0};
    endcase
  endfunction

endpackage

// File: rtl/vls_remap.sv
`timescale 1ns/1ps
module vls_remap #(
  parameter int DIMW = 2,
  parameter int OFFW = 4,
  parameter int ELW  = 6,
  parameter int IXW  = 6,
  localparam int SHW = 3*DIMW + 3 + OFFW,
  localparam int W   = ELW + OFFW + 3*DIMW + 2
) (
  input  logic [SHW-1:0] cfg,
  input  logic [ELW-1:0] elem,
  output logic [IXW-1:0] idx
);
  import vls_pkg::*;

  logic [OFFW-1:0]       shift;
  logic [2:0]            code;
  logic [2:0][W-1:0]     lim;
  logic [5:0]            ord;
  logic [1:0]            o0, o1, o2;
  logic [W-1:0]          tot, t, t1, l0, l1;
  logic [2:0][W-1:0]     ix;

  assign shift  = cfg[OFFW-1:0];
  assign code   = cfg[OFFW+2:OFFW];
  assign lim[0] = W'(cfg[OFFW+3 +: DIMW]) + W'(1);
  assign lim[1] = W'(cfg[OFFW+3+DIMW +: DIMW]) + W'(1);
  assign lim[2] = W'(cfg[OFFW+3+2*DIMW +: DIMW]) + W'(1);
  assign ord    = perm_order(code);
  assign o0     = ord[1:0];
  assign o1     = ord[3:2];
  assign o2     = ord[5:4];

  // Closed form of the stepped counter: mixed-radix split in axis order
  always_comb begin
    tot = lim[0] * lim[1] * lim[2];
    t   = (W'(elem) + W'(shift)) % tot;
    l0  = lim[o0];
    l1  = lim[o1];
    t1  = t / l0;
    ix  = '0;
    ix[o0] = t % l0;
    ix[o1] = t1 % l1;
    ix[o2] = t1 / l1;
    idx = IXW'(ix[0] + ix[1] * lim[0] + ix[2] * lim[0] * lim[1]);
  end

endmodule

// File: rtl/vls_operand.sv
`timescale 1ns/1ps
module vls_operand #(
  parameter int NREG   = 32,
  parameter int NSHAPE = 4,
  parameter int DIMW   = 2,
  parameter int OFFW   = 4,
  parameter int ELW    = 6,
  localparam int REGW  = $clog2(NREG),
  localparam int SELW  = $clog2(NSHAPE) + 1,
  localparam int SHW   = 3*DIMW + 3 + OFFW,
  localparam int IXW   = (ELW > 3*DIMW) ? ELW : 3*DIMW,
  localparam int RNW   = ((REGW > IXW) ? REGW : IXW) + 1
) (
  input  logic [REGW-1:0]       base,
  input  logic                  is_vec,
  input  logic [SELW-1:0]       sel,
  input  logic [NSHAPE*SHW-1:0] cfg,
  input  logic [ELW-1:0]        elem,
  output logic [REGW-1:0]       reg_o,
  output logic                  ovf
);

  logic [SHW-1:0] sh;
  logic [ELW-1:0] lin;
  logic [IXW-1:0] rm, off;
  logic [RNW-1:0] rn;

  assign sh  = cfg[int'(sel[SELW-2:0])*SHW +: SHW];
  assign lin = is_vec ? elem : '0;

  vls_remap #(.DIMW(DIMW), .OFFW(OFFW), .ELW(ELW), .IXW(IXW)) u_remap (
    .cfg (sh),
    .elem(lin),
    .idx (rm)
  );

  assign off   = sel[SELW-1] ? rm : IXW'(lin);
  assign rn    = RNW'(base) + RNW'(off);
  assign ovf   = (rn >= RNW'(NREG));
  assign reg_o = rn[REGW-1:0];

endmodule

// File: rtl/vloop_seq.sv
`timescale 1ns/1ps
module vloop_seq #(
  parameter int NREG   = 32,
  parameter int MAXVL  = 64,
  parameter int NSHAPE = 4,
  parameter int DIMW   = 2,
  parameter int OFFW   = 4,
  localparam int ELW   = $clog2(MAXVL),
  localparam int VLW   = ELW + 1,
  localparam int REGW  = $clog2(NREG),
  localparam int SELW  = $clog2(NSHAPE) + 1,
  localparam int SHW   = 3*DIMW + 3 + OFFW,
  localparam int NOP   = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic                  resume,
  input  logic [VLW-1:0]        vl,
  input  logic [MAXVL-1:0]      pred,
  input  logic [REGW-1:0]       rd_base,
  input  logic [REGW-1:0]       rs1_base,
  input  logic [REGW-1:0]       rs2_base,
  input  logic                  rd_vec,
  input  logic                  rs1_vec,
  input  logic                  rs2_vec,
  input  logic [SELW-1:0]       rd_map,
  input  logic [SELW-1:0]       rs1_map,
  input  logic [SELW-1:0]       rs2_map,
  input  logic [NSHAPE*SHW-1:0] shape_cfg,
  output logic                  busy,
  output logic                  issue,
  output logic [REGW-1:0]       rd_idx,
  output logic [REGW-1:0]       rs1_idx,
  output logic [REGW-1:0]       rs2_idx,
  output logic                  done,
  output logic                  err,
  output logic [ELW-1:0]        elem_state
);
  import vls_pkg::*;

  seq_st_t                   st;
  logic [ELW-1:0]            cnt;
  logic [ELW-1:0]            first;
  logic [NOP-1:0][REGW-1:0]  op_base;
  logic [NOP-1:0]            op_vec;
  logic [NOP-1:0][SELW-1:0]  op_sel;
  logic [NOP-1:0][REGW-1:0]  op_reg;
  logic [NOP-1:0]            op_ovf;
  logic                      active, any_ovf, last_el, empty;

  assign op_base = {rs2_base, rs1_base, rd_base};
  assign op_vec  = {rs2_vec, rs1_vec, rd_vec};
  assign op_sel  = {rs2_map, rs1_map, rd_map};

  for (genvar g = 0; g < NOP; g++) begin : g_op
    vls_operand #(
      .NREG(NREG), .NSHAPE(NSHAPE), .DIMW(DIMW), .OFFW(OFFW), .ELW(ELW)
    ) u_op (
      .base  (op_base[g]),
      .is_vec(op_vec[g]),
      .sel   (op_sel[g]),
      .cfg   (shape_cfg),
      .elem  (cnt),
      .reg_o (op_reg[g]),
      .ovf   (op_ovf[g])
    );
  end

  assign active  = pred[cnt];
  assign any_ovf = |op_ovf;
  assign last_el = ({1'b0, cnt} + VLW'(1)) == vl;
  assign first   = resume ? elem_state : '0;
  assign empty   = {1'b0, first} >= vl;
  assign busy    = (st == SEQ_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= SEQ_IDLE;
      cnt        <= '0;
      elem_state <= '0;
      issue      <= 1'b0;
      done       <= 1'b0;
      err        <= 1'b0;
      rd_idx     <= '0;
      rs1_idx    <= '0;
      rs2_idx    <= '0;
    end else begin
      issue <= 1'b0;
      done  <= 1'b0;
      err   <= 1'b0;
      case (st)
        SEQ_IDLE: begin
          if (start) begin
            elem_state <= first;
            if (empty) begin
              done <= 1'b1;
            end else begin
              cnt <= first;
              st  <= SEQ_RUN;
            end
          end
        end
        default: begin
          elem_state <= cnt;
          if (active && any_ovf) begin
            err <= 1'b1;
            st  <= SEQ_IDLE;
          end else begin
            issue <= active;
            if (active) begin
              rd_idx  <= op_reg[0];
              rs1_idx <= op_reg[1];
              rs2_idx <= op_reg[2];
            end
            if ((active && !rd_vec) || last_el) begin
              done <= 1'b1;
              st   <= SEQ_IDLE;
            end else begin
              cnt <= cnt + ELW'(1);
            end
          end
        end
      endcase
    end
  end

  // R9
  err_blocks_issue_chk: assert property (@(posedge clk) disable iff (rst)
    err |-> !issue);

  // R8
  done_not_err_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!err && !busy));

  // R2
  one_step_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> (cnt == $past(cnt) + ELW'(1)));

  // R7
  scalar_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (issue && !$past(rd_vec)) |-> (done && !busy));

  // R2
  track_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> (elem_state == $past(cnt)));

endmodule

// File: tb/test_vloop_seq.sv
`timescale 1ns/1ps
module test_vloop_seq;

  localparam int NREG = 128;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0, resume = 1'b0;
  logic [6:0]  vl = '0;
  logic [63:0] pred = '0;
  logic [6:0]  rd_base = '0, rs1_base = '0, rs2_base = '0;
  logic        rd_vec = 1'b1, rs1_vec = 1'b1, rs2_vec = 1'b1;
  logic [2:0]  rd_map = '0, rs1_map = '0, rs2_map = '0;
  logic [51:0] shape_cfg = '0;
  logic        busy, issue, done, err;
  logic [6:0]  rd_idx, rs1_idx, rs2_idx;
  logic [5:0]  elem_state;

  int nchk = 0, nfail = 0, m_state = 0;

  always #2.5 clk = ~clk;

  vloop_seq #(.NREG(NREG)) i_vloop_seq (
    .clk(clk), .rst(rst), .start(start), .resume(resume), .vl(vl), .pred(pred),
    .rd_base(rd_base), .rs1_base(rs1_base), .rs2_base(rs2_base),
    .rd_vec(rd_vec), .rs1_vec(rs1_vec), .rs2_vec(rs2_vec),
    .rd_map(rd_map), .rs1_map(rs1_map), .rs2_map(rs2_map),
    .shape_cfg(shape_cfg), .busy(busy), .issue(issue),
    .rd_idx(rd_idx), .rs1_idx(rs1_idx), .rs2_idx(rs2_idx),
    .done(done), .err(err), .elem_state(elem_state)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [12:0] mk(input int xm, input int ym, input int zm,
                                     input int pm, input int sh);
    return {2'(zm), 2'(ym), 2'(xm), 3'(pm), 4'(sh)};
  endfunction

  // Stepped-counter model of a shape walk
  function automatic int ref_remap(input logic [12:0] c, input int e);
    int lim[3];
    int ord[3];
    int ix[3];
    lim[0] = int'(c[8:7]) + 1;
    lim[1] = int'(c[10:9]) + 1;
    lim[2] = int'(c[12:11]) + 1;
    case (c[6:4])
      3'd1:    begin ord[0] = 0; ord[1] = 2; ord[2] = 1; end
      3'd2:    begin ord[0] = 1; ord[1] = 0; ord[2] = 2; end
      3'd3:    begin ord[0] = 1; ord[1] = 2; ord[2] = 0; end
      3'd4:    begin ord[0] = 2; ord[1] = 0; ord[2] = 1; end
      3'd5:    begin ord[0] = 2; ord[1] = 1; ord[2] = 0; end
      default: begin ord[0] = 0; ord[1] = 1; ord[2] = 2; end
    endcase
    ix[0] = 0; ix[1] = 0; ix[2] = 0;
    for (int s = 0; s < e + int'(c[3:0]); s++) begin
      for (int k = 0; k < 3; k++) begin
        ix[ord[k]]++;
        if (ix[ord[k]] != lim[ord[k]]) break;
        ix[ord[k]] = 0;
      end
    end
    return ix[0] + ix[1]*lim[0] + ix[2]*lim[0]*lim[1];
  endfunction

  function automatic int exp_reg(input int base, input bit vec, input logic [2:0] sel, input int e);
    int lin;
    lin = vec ? e : 0;
    if (sel[2]) return base + ref_remap(shape_cfg[int'(sel[1:0])*13 +: 13], lin);
    return base + lin;
  endfunction

  task automatic run_op();
    int s, n, erd, ers1, ers2;
    bit act, ovf, fin;
    s = resume ? m_state : 0;
    n = int'(vl);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(elem_state == 6'(s), "R10 start element", int'(elem_state), s);
    if (s >= n) begin
      chk(done && !busy && !issue, "R8 empty done", int'(done), 1);
      m_state = s;
      @(negedge clk);
      chk(!done && !busy, "R8 single pulse", int'(done), 0);
      return;
    end
    for (int i = s; i < n; i++) begin
      @(negedge clk);
      act  = pred[i];
      erd  = exp_reg(int'(rd_base), rd_vec, rd_map, i);
      ers1 = exp_reg(int'(rs1_base), rs1_vec, rs1_map, i);
      ers2 = exp_reg(int'(rs2_base), rs2_vec, rs2_map, i);
      ovf  = (erd >= NREG) || (ers1 >= NREG) || (ers2 >= NREG);
      m_state = i;
      chk(elem_state == 6'(i), "R2 element state", int'(elem_state), i);
      if (act && ovf) begin
        chk(err && !issue && !done, "R9 overrun error", int'(err), 1);
        @(negedge clk);
        chk(!busy && !err && elem_state == 6'(i), "R9 halted", int'(elem_state), i);
        return;
      end
      chk(!err, "R9 no error", int'(err), 0);
      chk(issue == act, "R3 predicate", int'(issue), int'(act));
      if (act) begin
        chk(int'(rd_idx) == erd, "R5 rd index", int'(rd_idx), erd);
        chk(int'(rs1_idx) == ers1, "R4 rs1 index", int'(rs1_idx), ers1);
        chk(int'(rs2_idx) == ers2, "R6 rs2 index", int'(rs2_idx), ers2);
      end
      fin = (act && !rd_vec) || (i == n - 1);
      chk(done == fin, "R7 R8 done", int'(done), int'(fin));
      if (fin) break;
    end
    @(negedge clk);
    chk(!busy && !done && !issue, "R8 idle after done", int'(busy), 0);
  endtask

  initial begin
    #1000000;
    nchk++; nfail++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1
    chk(!busy && !issue && !done && !err && elem_state == 0, "R1 reset", int'(busy), 0);
    rst = 1'b0;
    @(negedge clk);

    // Shape sweep: all sizes, all orders, varying shift, length past the shape
    for (int p = 0; p < 6; p++)
      for (int x = 0; x < 4; x++)
        for (int y = 0; y < 4; y++)
          for (int z = 0; z < 4; z++) begin
            int tot;
            shape_cfg = {mk(3,0,1,1,2), mk(1,3,0,4,7), mk(2,2,0,2,1),
                         mk(x, y, z, p, (p*3 + x + y + z) % 16)};
            tot = (x+1)*(y+1)*(z+1);
            vl  = 7'((tot + x + 1 > 64) ? 64 : tot + x + 1);
            pred = '1;
            rd_base = 7'd0;  rd_vec = 1'b1;  rd_map = 3'b100;
            rs1_base = 7'd10; rs1_vec = 1'b1; rs1_map = 3'b000;
            rs2_base = 7'd3; rs2_vec = 1'b1; rs2_map = {1'b1, 2'(x)};
            resume = 1'b0;
            run_op();
          end

    // R3: predicate patterns
    shape_cfg = {mk(3,0,1,1,2), mk(1,3,0,4,7), mk(2,2,0,2,1), mk(3,1,0,2,0)};
    vl = 7'd40;
    pred = 64'hAAAA_AAAA_AAAA_AAAA; run_op();
    pred = {$urandom, $urandom};    run_op();
    pred = {$urandom, $urandom};    run_op();
    pred = '0;                      run_op();

    // R4: scalar sources, one shifted through a shape
    rs1_vec = 1'b0; rs1_map = 3'b101; rs2_vec = 1'b0; rs2_map = 3'b000;
    pred = '1; vl = 7'd12; run_op();

    // R7: scalar destination stops at first issued element
    rd_vec = 1'b0; rd_map = 3'b000; rs1_vec = 1'b1; rs2_vec = 1'b1;
    pred = 64'hF0; vl = 7'd20; run_op();
    pred = '0; run_op();
    rd_vec = 1'b1;

    // R8: zero length
    vl = 7'd0; pred = '1; run_op();

    // R9 / R10: over-run, then resume chain
    rd_map = 3'b000; rs1_map = 3'b000; rs2_map = 3'b000;
    rs1_base = 7'd0; rs2_base = 7'd0;
    rd_base = 7'd120; vl = 7'd20; pred = '1; run_op();
    chk(m_state == 8, "R9 fault element", m_state, 8);
    rd_base = 7'd100; resume = 1'b1; run_op();
    run_op();
    vl = 7'd10; run_op();
    resume = 1'b0;

    // R9: over-run only on skipped elements is ignored
    rd_base = 7'd120; vl = 7'd20; pred = 64'hFF; run_op();
    chk(m_state == 19, "R9 skipped overrun", m_state, 19);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

endmodule